// File: doc/BRIEF.md
# Private Interrupt Best-Candidate Selector

This block keeps the pending and active state of a processor's private interrupts (32 by default) and continuously picks the single best interrupt to present to the processor interface. Configuration is supplied from outside the block: a per-interrupt enable bit, an 8-bit priority, a resolved 2-bit group code, and one enable bit for each group. From these inputs and its own state, the block reports the winning interrupt's ID, priority and group, together with a valid flag.

Pending bits are raised by set pulses. An acknowledge turns a pending interrupt into an active one. A deactivate ends the active phase. A query port returns the 2-bit state code of any one interrupt. The search runs as a two-stage registered reduction tree. Its result reflects all inputs sampled at one clock edge and is visible after the following edge.

Top module: `ppi_hppi_select`

## Requirements
- R1: After reset every interrupt is inactive and not pending. The outputs are then hp_valid=0, hp_id=1023, hp_prio=0xFF and hp_grp=0.
- R2: An interrupt can be selected only if all of these hold: its pending bit is set, its irq_en bit is 1, its active bit is clear, its group code is 0, 1 or 2, and grp_en[code] is 1. Group code 3 is never selectable.
- R3: Among selectable interrupts, the one with the numerically smallest priority value (irq_prio[8*i+:8]) is chosen.
- R4: When several selectable interrupts share the smallest priority value, the one with the lowest ID is chosen.
- R5: When no interrupt is selectable, the outputs are hp_valid=0, hp_id=1023, hp_prio=0xFF and hp_grp=0.
- R6: Inputs sampled at clock edge E, together with the state those inputs produce, appear on the hp_* outputs after edge E+1. After edge E alone the outputs still show the previous result.
- R7: An acknowledge (ack_vld with ack_id) clears that interrupt's pending bit and sets its active bit. If set_pend raises the same bit in the same cycle, the pending bit stays set.
- R8: A deactivate (deact_vld with deact_id) clears only the active bit. If an acknowledge for the same ID arrives in the same cycle, the acknowledge wins and the interrupt is active afterwards.
- R9: qry_state returns the state of interrupt qry_id combinationally from registered state, as a 2-bit code {active, pending}: 0 means inactive, 1 pending, 2 active, and 3 active and pending.
- R10: A 1 on set_pend[i] sets pending bit i at the next edge. A pending bit clears only when that interrupt is acknowledged.
- R11: hp_grp carries the group code of the selected interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_pend | input | N_IRQ | Per-interrupt pending set pulses |
| irq_en | input | N_IRQ | Per-interrupt enable |
| irq_prio | input | 8*N_IRQ | Priorities, 8 bits per interrupt, lower value is more urgent |
| irq_grp | input | 2*N_IRQ | Resolved group code per interrupt (0, 1, 2; 3 reserved) |
| grp_en | input | 3 | Enable for group codes 0..2 |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_id | input | clog2(N_IRQ) | Interrupt being acknowledged |
| deact_vld | input | 1 | Deactivate strobe |
| deact_id | input | clog2(N_IRQ) | Interrupt being deactivated |
| qry_id | input | clog2(N_IRQ) | Interrupt whose state code is read |
| qry_state | output | 2 | {active, pending} of qry_id |
| hp_valid | output | 1 | A selectable interrupt exists |
| hp_id | output | 10 | Selected interrupt ID, 1023 when none |
| hp_prio | output | 8 | Selected priority, 0xFF when none |
| hp_grp | output | 2 | Group code of the selected interrupt |

## Verification
Several properties are checked on every cycle. The idle encoding must hold whenever hp_valid is low. The valid flag must match, two edges later, whether any interrupt was eligible. Acknowledge and deactivate must have their effect on the state bits. No pending bit may drop without an acknowledge. Which interrupt wins is shown only by the bench's scenarios. That covers priority ordering, tie-breaking by ID, masking by enable, active state, group code and group enable, the one-edge-late latency observation, and the same-cycle collisions between set, acknowledge and deactivate. The bench compares every result against a reference model of the requirements, under both directed and seeded random stimulus.

// File: rtl/ppi_sel_pkg.sv
package ppi_sel_pkg;

  localparam int PRIO_W   = 8;
  localparam int OUT_ID_W = 10;
  localparam int GRP_W    = 2;
  localparam int N_GRP_EN = 3;

  localparam logic [OUT_ID_W-1:0] NO_ID   = '1;
  localparam logic [PRIO_W-1:0]   NO_PRIO = '1;
  localparam logic [GRP_W-1:0]    GRP_RSV = 2'd3;

  typedef struct packed {
    logic                vld;
    logic [PRIO_W-1:0]   prio;
    logic [OUT_ID_W-1:0] id;
    logic [GRP_W-1:0]    grp;
  } cand_t;

  localparam cand_t CAND_IDLE = '{vld: 1'b0, prio: NO_PRIO, id: NO_ID, grp: '0};

endpackage

// File: rtl/ppi_state_bank.sv
module ppi_state_bank #(
  parameter int N_IRQ = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IRQ-1:0]         set_pend,
  input  logic                     ack_vld,
  input  logic [$clog2(N_IRQ)-1:0] ack_id,
  input  logic                     deact_vld,
  input  logic [$clog2(N_IRQ)-1:0] deact_id,
  output logic [N_IRQ-1:0]         pend_q,
  output logic [N_IRQ-1:0]         act_q,
  output logic [N_IRQ-1:0]         pend_d,
  output logic [N_IRQ-1:0]         act_d
);

  logic [N_IRQ-1:0] ack_mask;
  logic [N_IRQ-1:0] deact_mask;
  logic             st_en;

  always_comb begin
    ack_mask   = ack_vld   ? (N_IRQ'(1) << ack_id)   : '0;
    deact_mask = deact_vld ? (N_IRQ'(1) << deact_id) : '0;
    pend_d     = (pend_q & ~ack_mask) | set_pend;
    act_d      = (act_q & ~deact_mask) | ack_mask;
    st_en      = (|set_pend) | ack_vld | deact_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
    end else if (st_en) begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  // R7: acknowledge moves the interrupt from pending to active
  a_r7_ack_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vld && !set_pend[ack_id]) |=> (!pend_q[$past(ack_id)] && act_q[$past(ack_id)]));

  // R8: deactivate clears active and leaves pending untouched
  a_r8_deact_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (deact_vld && !(ack_vld && ack_id == deact_id) && !set_pend[deact_id])
    |=> (!act_q[$past(deact_id)] && pend_q[$past(deact_id)] == $past(pend_q[deact_id])));

  // R10: a pending bit only drops when acknowledged
  a_r10_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pend_q & $past(pend_q) & ~$past(ack_mask)) == '0));

endmodule

// File: rtl/ppi_cand_reduce.sv
module ppi_cand_reduce #(
  parameter int M = 8
) (
  input  ppi_sel_pkg::cand_t c_in [M],
  output ppi_sel_pkg::cand_t c_out
);

  // Inputs arrive in ascending ID order; a strict compare keeps the lower ID on ties.
  always_comb begin
    c_out = c_in[0];
    for (int i = 1; i < M; i++) begin
      if (c_in[i].vld && (!c_out.vld || c_in[i].prio < c_out.prio)) begin
        c_out = c_in[i];
      end
    end
  end

endmodule

// File: rtl/ppi_hppi_select.sv
module ppi_hppi_select #(
  parameter int N_IRQ = 32,
  parameter int LEAF  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IRQ-1:0]         set_pend,
  input  logic [N_IRQ-1:0]         irq_en,
  input  logic [8*N_IRQ-1:0]       irq_prio,
  input  logic [2*N_IRQ-1:0]       irq_grp,
  input  logic [2:0]               grp_en,
  input  logic                     ack_vld,
  input  logic [$clog2(N_IRQ)-1:0] ack_id,
  input  logic                     deact_vld,
  input  logic [$clog2(N_IRQ)-1:0] deact_id,
  input  logic [$clog2(N_IRQ)-1:0] qry_id,
  output logic [1:0]               qry_state,
  output logic                     hp_valid,
  output logic [9:0]               hp_id,
  output logic [7:0]               hp_prio,
  output logic [1:0]               hp_grp
);
  import ppi_sel_pkg::*;

  localparam int N_BLK = N_IRQ / LEAF;

  logic [N_IRQ-1:0] pend_q, act_q, pend_d, act_d;
  logic [N_IRQ-1:0] elig;
  cand_t            leaf_c [N_IRQ];
  cand_t            s1_d   [N_BLK];
  cand_t            s1_q   [N_BLK];
  cand_t            s2_d;
  cand_t            out_q;
  logic             any_elig;

  ppi_state_bank #(.N_IRQ(N_IRQ)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_pend (set_pend),
    .ack_vld  (ack_vld),
    .ack_id   (ack_id),
    .deact_vld(deact_vld),
    .deact_id (deact_id),
    .pend_q   (pend_q),
    .act_q    (act_q),
    .pend_d   (pend_d),
    .act_d    (act_d)
  );

  // Leaf candidates built from next-state so all inputs of one edge line up
  always_comb begin
    for (int i = 0; i < N_IRQ; i++) begin
      logic [GRP_W-1:0] g;
      logic             g_ok;
      g       = irq_grp[GRP_W*i +: GRP_W];
      g_ok    = (g != GRP_RSV) && grp_en[g];
      elig[i] = pend_d[i] && irq_en[i] && !act_d[i] && g_ok;
      if (elig[i]) begin
        leaf_c[i] = '{vld: 1'b1, prio: irq_prio[PRIO_W*i +: PRIO_W],
                      id: OUT_ID_W'(i), grp: g};
      end else begin
        leaf_c[i] = CAND_IDLE;
      end
    end
    any_elig = |elig;
  end

  // Stage 1: one reducer per block of LEAF interrupts
  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    cand_t blk_in [LEAF];
    for (genvar k = 0; k < LEAF; k++) begin : g_leaf
      assign blk_in[k] = leaf_c[b*LEAF + k];
    end
    ppi_cand_reduce #(.M(LEAF)) u_red (
      .c_in (blk_in),
      .c_out(s1_d[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < N_BLK; b++) s1_q[b] <= CAND_IDLE;
    end else begin
      for (int b = 0; b < N_BLK; b++) s1_q[b] <= s1_d[b];
    end
  end

  // Stage 2: reduce block winners in ascending block order
  ppi_cand_reduce #(.M(N_BLK)) u_red_top (
    .c_in (s1_q),
    .c_out(s2_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= CAND_IDLE;
    else        out_q <= s2_d;
  end

  assign hp_valid  = out_q.vld;
  assign hp_id     = out_q.id;
  assign hp_prio   = out_q.prio;
  assign hp_grp    = out_q.grp;
  assign qry_state = {act_q[qry_id], pend_q[qry_id]};

  // Cycles since reset, used only to qualify the latency check
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  // R5: idle encoding whenever nothing is selected
  a_r5_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_valid |-> (hp_id == NO_ID && hp_prio == NO_PRIO && hp_grp == '0));

  // R6: valid flag follows eligibility two edges later
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 2'd2) |-> (hp_valid == $past(any_elig, 2)));

  // R2: a valid selection is a real interrupt ID with a usable group
  a_r2_valid_range: assert property (@(posedge clk) disable iff (!rst_n)
    hp_valid |-> (hp_id < N_IRQ && hp_grp != GRP_RSV));

endmodule

// File: tb/ppi_hppi_select_test.sv
module ppi_hppi_select_test;

  localparam int N  = 32;
  localparam int TP = 10;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [N-1:0]   set_pend;
  logic [N-1:0]   irq_en;
  logic [8*N-1:0] irq_prio;
  logic [2*N-1:0] irq_grp;
  logic [2:0]     grp_en;
  logic           ack_vld;
  logic [4:0]     ack_id;
  logic           deact_vld;
  logic [4:0]     deact_id;
  logic [4:0]     qry_id;
  logic [1:0]     qry_state;
  logic           hp_valid;
  logic [9:0]     hp_id;
  logic [7:0]     hp_prio;
  logic [1:0]     hp_grp;

  int n_chk  = 0;
  int n_fail = 0;
  logic [N-1:0] m_pend, m_act;

  always #(TP/2) clk = ~clk;

  ppi_hppi_select #(.N_IRQ(N), .LEAF(8)) uut (
    .clk(clk), .rst_n(rst_n), .set_pend(set_pend), .irq_en(irq_en),
    .irq_prio(irq_prio), .irq_grp(irq_grp), .grp_en(grp_en),
    .ack_vld(ack_vld), .ack_id(ack_id), .deact_vld(deact_vld),
    .deact_id(deact_id), .qry_id(qry_id), .qry_state(qry_state),
    .hp_valid(hp_valid), .hp_id(hp_id), .hp_prio(hp_prio), .hp_grp(hp_grp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic exp_sel(output bit v, output int id, output int pr, output int g);
    v = 0; id = 1023; pr = 255; g = 0;
    for (int i = 0; i < N; i++) begin
      int gi;
      bit ok;
      gi = int'(irq_grp[2*i +: 2]);
      ok = m_pend[i] && irq_en[i] && !m_act[i] && gi != 3 && grp_en[gi];
      if (ok && (!v || int'(irq_prio[8*i +: 8]) < pr)) begin
        v = 1; id = i; pr = int'(irq_prio[8*i +: 8]); g = gi;
      end
    end
  endtask

  task automatic check_sel(input string req);
    bit v; int id, pr, g;
    exp_sel(v, id, pr, g);
    chk(hp_valid == v, req, "hp_valid", int'(hp_valid), int'(v));
    chk(int'(hp_id) == id && int'(hp_prio) == pr && int'(hp_grp) == g, req,
        "hp_id*1000+prio(grp in low)", int'(hp_id) * 1000 + int'(hp_prio) * 4 + int'(hp_grp),
        id * 1000 + pr * 4 + g);
  endtask

  task automatic check_state(input int id, input string req);
    logic [1:0] e;
    qry_id = 5'(id);
    #1;
    e = {m_act[id], m_pend[id]};
    chk(qry_state == e, req, "qry_state", int'(qry_state), int'(e));
  endtask

  // Drive one cycle of pulses at a negedge, update the model at the edge,
  // then wait one more edge so the selection has settled.
  task automatic step(input logic [N-1:0] s, input bit av, input int ai,
                      input bit dv, input int di);
    logic [N-1:0] am, dm;
    @(negedge clk);
    set_pend = s; ack_vld = av; ack_id = 5'(ai); deact_vld = dv; deact_id = 5'(di);
    am = av ? (N'(1) << ai) : '0;
    dm = dv ? (N'(1) << di) : '0;
    @(posedge clk);
    m_pend = (m_pend & ~am) | s;
    m_act  = (m_act & ~dm) | am;
    @(negedge clk);
    set_pend = '0; ack_vld = 0; deact_vld = 0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(TP * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd4711);
    rst_n = 0; set_pend = '0; ack_vld = 0; ack_id = '0; deact_vld = 0;
    deact_id = '0; qry_id = '0; m_pend = '0; m_act = '0;
    irq_en = '1; grp_en = 3'b111;
    for (int i = 0; i < N; i++) begin
      irq_prio[8*i +: 8] = 8'h40;
      irq_grp[2*i +: 2]  = 2'd2;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    chk(!hp_valid && hp_id == 10'd1023 && hp_prio == 8'hFF && hp_grp == 2'd0,
        "R1", "reset outputs", int'(hp_id), 1023);
    check_state(7, "R1");

    // R6: latency, one edge late still old, two edges new
    set_pend = N'(1) << 5;
    @(posedge clk);
    m_pend[5] = 1'b1;
    @(negedge clk);
    set_pend = '0;
    chk(!hp_valid, "R6", "valid after one edge", int'(hp_valid), 0);
    @(posedge clk);
    @(negedge clk);
    chk(hp_valid && hp_id == 10'd5, "R6", "id after two edges", int'(hp_id), 5);
    check_sel("R11");

    // R2: masking by enable, group enable and reserved group
    irq_en[5] = 1'b0;       step('0, 0, 0, 0, 0); check_sel("R2"); check_sel("R5");
    irq_en[5] = 1'b1;       grp_en = 3'b011; step('0, 0, 0, 0, 0); check_sel("R2");
    grp_en = 3'b111;        irq_grp[2*5 +: 2] = 2'd3; step('0, 0, 0, 0, 0); check_sel("R2");
    irq_grp[2*5 +: 2] = 2'd1; step('0, 0, 0, 0, 0); check_sel("R11");

    // R3: lower priority value wins, R4: tie to lower ID
    irq_prio[8*9 +: 8] = 8'h10; step(N'(1) << 9, 0, 0, 0, 0); check_sel("R3");
    chk(hp_id == 10'd9, "R3", "winner", int'(hp_id), 9);
    irq_prio[8*3 +: 8] = 8'h10; step(N'(1) << 3, 0, 0, 0, 0); check_sel("R4");
    chk(hp_id == 10'd3, "R4", "tie winner", int'(hp_id), 3);
    irq_prio[8*31 +: 8] = 8'hFF; irq_prio[8*30 +: 8] = 8'hFF;

    // R7: acknowledge, R9 state codes, R8 deactivate
    step('0, 1, 3, 0, 0); check_sel("R7"); check_state(3, "R7");
    chk(hp_id == 10'd9, "R7", "active excluded", int'(hp_id), 9);
    step(N'(1) << 3, 0, 0, 0, 0); check_state(3, "R9"); check_sel("R9");
    step('0, 0, 0, 1, 3); check_state(3, "R8"); check_sel("R8");
    step('0, 1, 3, 1, 3); check_state(3, "R8"); check_sel("R8");
    step(N'(1) << 3, 1, 3, 0, 0); check_state(3, "R7"); check_sel("R10");
    step('0, 0, 0, 1, 3); check_sel("R10");

    // Random phase
    for (int it = 0; it < 400; it++) begin
      logic [N-1:0] s;
      bit av, dv;
      int ai, di;
      if ($urandom_range(0, 3) == 0) begin
        for (int i = 0; i < N; i++) begin
          case ($urandom_range(0, 4))
            0: irq_prio[8*i +: 8] = 8'h00;
            1: irq_prio[8*i +: 8] = 8'h01;
            2: irq_prio[8*i +: 8] = 8'hFF;
            default: irq_prio[8*i +: 8] = 8'($urandom_range(0, 255));
          endcase
          irq_grp[2*i +: 2] = 2'($urandom_range(0, 3));
        end
        irq_en = $urandom | $urandom;
        grp_en = 3'($urandom_range(0, 7));
      end
      s  = $urandom & $urandom & $urandom;
      av = $urandom_range(0, 1) == 1;
      ai = hp_valid ? int'(hp_id) : $urandom_range(0, N - 1);
      dv = $urandom_range(0, 2) == 0;
      di = $urandom_range(0, N - 1);
      step(s, av, ai, dv, di);
      check_sel("R3");
      check_state($urandom_range(0, N - 1), "R9");
    end

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule